// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse-Width Modulator

This block generates two independent pulse-width modulated outputs behind one small register port. Each channel holds three registers: a control word (a 6-bit clock divider and a stop-mode bit), a duty word (a 10-bit high count plus a force-high bit) and a period word (a 10-bit count). The input clock is divided by the divider value plus one. Each divided tick advances a period counter. The output is high while that counter is below the duty count and low for the rest of the period.

Software writes the registers while a channel's enable input is high. The counting logic works from a private copy of the settings. That copy is reloaded only when a period ends or when the channel starts, so every period runs with one consistent setting. When the enable drops, the stop-mode bit chooses the behaviour: the channel either finishes the period in progress or parks low at once. The second channel's registers sit 0x10 bytes above the first channel's.

Top module: `pwm_dual`

## Requirements
- R1: Byte addresses, with bit 4 selecting the channel: offset 0x00 is control (divider in bits 5:0, stop-mode bit 6), 0x04 is duty (count in bits 9:0, force-high bit 10), 0x08 is period (count in bits 9:0). Reads return the stored fields, unused bits read 0, and offset 0x0C reads 0.
- R2: A write to a channel whose enable is low leaves that channel's registers unchanged.
- R3: With divider P and period count V, one output period lasts (P+1)*(V+1) clock cycles.
- R4: With duty count D, where 0 < D <= V, each period starts with (P+1)*D high cycles, followed by low cycles for the rest of the period.
- R5: With the force-high bit set, the output stays high whatever the duty count.
- R6: A duty count of 0 gives a constant low output. A duty count of at least V+1 gives a constant high output.
- R7: New divider, duty and period values take effect only at the next period boundary, or when a stopped channel starts.
- R8: When the enable drops with the stop-mode bit at 0, the current period completes, and then the output stays low.
- R9: When the enable drops with the stop-mode bit at 1, the output is low from the next clock cycle.
- R10: After a synchronous active-low reset, all registers read 0 and both outputs are low.
- R11: The two channels count and drive their outputs independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Byte address: bit 4 selects the channel, bits 3:2 select the register |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ch_en | input | 2 | Enable for each channel |
| pwm_out | output | 2 | PWM output for each channel |

## Verification
Some properties are checked on every cycle:
- the registers of a disabled channel never change;
- the working copy of the settings stays fixed between period boundaries;
- the counters stay within their programmed limits;
- a graceful stop keeps running until the boundary;
- an abrupt stop drops the output on the next cycle.

Other behaviour is shown only by the bench scenarios, which measure high and low run lengths at the outputs:
- the exact high time and period length for each divider and count setting;
- the constant-level cases;
- the delayed effect of a duty write made mid-period;
- channel independence.

// File: rtl/pwm_pkg.sv
// pwm_pkg: widths and types shared by the PWM channel logic.
// Assumes byte addressing with four 32-bit register slots per channel.
package pwm_pkg;
    localparam int DATA_W     = 16;  // bus data width, must cover bit 10
    localparam int PSC_W      = 6;   // clock divider field width
    localparam int CNT_W      = 10;  // duty and period count width
    localparam int REG_SPAN_W = 4;   // address bits per channel (0x10 bytes)
    localparam int SD_BIT     = 6;   // stop-mode bit in control word
    localparam int FULL_BIT   = 10;  // force-high bit in duty word

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_DUTY   = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             sd;
        logic [PSC_W-1:0] psc;
        logic             full;
        logic [CNT_W-1:0] dc;
        logic [CNT_W-1:0] pv;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_chan_regs.sv
// pwm_chan_regs: the register set of one channel.
// Writes are accepted only while the channel enable is high.
// Read data is combinational from the register select.
// Assumes wr_i is already qualified by channel decode and the bus strobe.
module pwm_chan_regs
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output chan_cfg_t         cfg_o,
    output logic [DATA_W-1:0] rdata_o
);
    chan_cfg_t cfg_q;

    // Capture the field selected by the write, gated by the channel enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_i && en_i) begin
            case (sel_i)
                SEL_CTRL: begin
                    cfg_q.psc <= wdata_i[PSC_W-1:0];
                    cfg_q.sd  <= wdata_i[SD_BIT];
                end
                SEL_DUTY: begin
                    cfg_q.dc   <= wdata_i[CNT_W-1:0];
                    cfg_q.full <= wdata_i[FULL_BIT];
                end
                SEL_PERIOD: cfg_q.pv <= wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Assemble the read word for the selected register.
    always_comb begin
        rdata_o = '0;
        case (sel_i)
            SEL_CTRL: begin
                rdata_o[PSC_W-1:0] = cfg_q.psc;
                rdata_o[SD_BIT]    = cfg_q.sd;
            end
            SEL_DUTY: begin
                rdata_o[CNT_W-1:0] = cfg_q.dc;
                rdata_o[FULL_BIT]  = cfg_q.full;
            end
            SEL_PERIOD: rdata_o[CNT_W-1:0] = cfg_q.pv;
            default: rdata_o = '0;
        endcase
    end

    assign cfg_o = cfg_q;

    // R2: a disabled channel keeps its registers.
    p_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cfg_q));
endmodule

// File: rtl/pwm_chan_core.sv
// pwm_chan_core: divider, period counter and output for one channel.
// Works from a private copy of the settings, loaded at start and at period ends.
// Assumes cfg_i is the channel's register set; only its stop-mode bit acts at once.
module pwm_chan_core
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);
    chan_cfg_t        act_q;
    logic             running_q;
    logic [PSC_W-1:0] psc_cnt_q;
    logic [CNT_W-1:0] per_cnt_q;
    logic             tick;
    logic             period_end;
    logic             hard_stop;

    // Decode the divider wrap, the period end and an abrupt stop request.
    always_comb begin
        tick       = (psc_cnt_q == act_q.psc);
        period_end = running_q && tick && (per_cnt_q == act_q.pv);
        hard_stop  = running_q && !en_i && cfg_i.sd;
    end

    // Sequence start, counting, reloads and both stop modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            psc_cnt_q <= '0;
            per_cnt_q <= '0;
            act_q     <= '0;
        end else if (!running_q) begin
            if (en_i) begin
                running_q <= 1'b1;
                act_q     <= cfg_i;
                psc_cnt_q <= '0;
                per_cnt_q <= '0;
            end
        end else if (hard_stop) begin
            running_q <= 1'b0;
            psc_cnt_q <= '0;
            per_cnt_q <= '0;
        end else if (tick) begin
            psc_cnt_q <= '0;
            if (period_end) begin
                per_cnt_q <= '0;
                if (en_i) begin
                    act_q <= cfg_i;
                end else begin
                    running_q <= 1'b0;
                end
            end else begin
                per_cnt_q <= per_cnt_q + 1'b1;
            end
        end else begin
            psc_cnt_q <= psc_cnt_q + 1'b1;
        end
    end

    // Drive the output high for the leading duty part of each period.
    always_comb begin
        pwm_o = running_q && (act_q.full || (per_cnt_q < act_q.dc));
    end

    // R7: settings in use change only at a period end or at start.
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        running_q && !period_end |=> $stable(act_q));

    // R3: counters never pass their programmed limits.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (per_cnt_q <= act_q.pv) && (psc_cnt_q <= act_q.psc));

    // R8: a graceful stop keeps running until the period ends.
    p_graceful_r8: assert property (@(posedge clk) disable iff (!rst_n)
        running_q && !en_i && !cfg_i.sd && !period_end |=> running_q);

    // R9: an abrupt stop parks the output on the next cycle.
    p_abrupt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        running_q && !en_i && cfg_i.sd |=> !pwm_o);
endmodule

// File: rtl/pwm_dual.sv
// pwm_dual: N_CH PWM channels behind one register port, 0x10 bytes apart.
// Decodes the channel and register from the byte address and muxes the read data.
// Assumes N_CH >= 2; address bits 1:0 are ignored.
module pwm_dual
    import pwm_pkg::*;
#(
    parameter  int N_CH   = 2,
    localparam int CH_W   = $clog2(N_CH),
    localparam int ADDR_W = REG_SPAN_W + CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   ch_en,
    output logic [N_CH-1:0]   pwm_out
);
    logic [CH_W-1:0]   ch_idx;
    reg_sel_e          sel;
    logic [DATA_W-1:0] ch_rdata [N_CH];

    // Split the byte address into channel index and register select.
    always_comb begin
        ch_idx = bus_addr[ADDR_W-1:REG_SPAN_W];
        sel    = reg_sel_e'(bus_addr[REG_SPAN_W-1:2]);
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        chan_cfg_t cfg;
        logic      wr;

        // Qualify the bus strobe with this channel's address.
        always_comb begin
            wr = bus_we && (ch_idx == CH_W'(c));
        end

        pwm_chan_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (ch_en[c]),
            .wr_i    (wr),
            .sel_i   (sel),
            .wdata_i (bus_wdata),
            .cfg_o   (cfg),
            .rdata_o (ch_rdata[c])
        );

        pwm_chan_core u_core (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (ch_en[c]),
            .cfg_i (cfg),
            .pwm_o (pwm_out[c])
        );
    end

    // Return the addressed channel's read word, zero for unmapped channels.
    always_comb begin
        bus_rdata = '0;
        if (int'(ch_idx) < N_CH) begin
            bus_rdata = ch_rdata[ch_idx];
        end
    end
endmodule

// File: tb/sim_pwm_dual.sv
module sim_pwm_dual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic [1:0]  ch_en = '0;
    logic [1:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_dual u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .ch_en     (ch_en),
        .pwm_out   (pwm_out)
    );

    // Vectors: divider, period count, duty count (0 < duty <= period count).
    localparam int NV = 6;
    localparam int VEC [NV][3] = '{
        '{0, 9, 3}, '{2, 4, 1}, '{1, 7, 6},
        '{3, 2, 2}, '{0, 1, 1}, '{5, 3, 1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        bus_addr  = 5'(addr);
        bus_wdata = 16'(data);
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_check(input int addr, input int exp, input string tag);
        @(negedge clk);
        bus_addr = 5'(addr);
        #1;
        check(bus_rdata == 16'(exp), tag, int'(bus_rdata), exp);
    endtask

    // Program a channel, then stop it abruptly and start it, so it runs the new setting.
    task automatic restart(input int ch, input int psc, input int pv, input int duty);
        ch_en[ch] = 1'b1;
        wr(ch * 16 + 8, pv);
        wr(ch * 16 + 4, duty);
        wr(ch * 16 + 0, 32'h40 | psc);
        @(negedge clk);
        ch_en[ch] = 1'b0;
        @(negedge clk);
        ch_en[ch] = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_rise(input int ch);
        int t = 0;
        while (pwm_out[ch] !== 1'b0 && t < 2000) begin @(negedge clk); t++; end
        while (pwm_out[ch] !== 1'b1 && t < 4000) begin @(negedge clk); t++; end
    endtask

    task automatic measure(input int ch, output int hi, output int lo);
        int t = 0;
        hi = 0;
        lo = 0;
        wait_rise(ch);
        while (pwm_out[ch] === 1'b1 && t < 2000) begin hi++; @(negedge clk); t++; end
        while (pwm_out[ch] === 1'b0 && t < 4000) begin lo++; @(negedge clk); t++; end
    endtask

    function automatic int count_high(input int ch, input int n);
        return 0;
    endfunction

    task automatic sample_high(input int ch, input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch] === 1'b1) highs++;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi;
        int lo;
        int highs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        check(pwm_out == 2'b00, "R10 outputs low", int'(pwm_out), 0);
        for (int a = 0; a < 3; a++) begin
            rd_check(a * 4, 0, "R10 ch0 reg zero");
            rd_check(16 + a * 4, 0, "R10 ch1 reg zero");
        end

        // R1: register map and field widths
        ch_en[0] = 1'b1;
        wr(0, 32'h45);
        rd_check(0, 32'h45, "R1 control readback");
        wr(0, 32'hFFFF);
        rd_check(0, 32'h7F, "R1 control field mask");
        wr(4, 32'hFFFF);
        rd_check(4, 32'h7FF, "R1 duty field mask");
        wr(8, 32'hFFFF);
        rd_check(8, 32'h3FF, "R1 period field mask");
        rd_check(12, 0, "R1 unused slot");
        rd_check(16 + 8, 0, "R1 channel 1 separate");

        // R3 and R4: vector table walk
        for (int v = 0; v < NV; v++) begin
            int p = VEC[v][0];
            int pv = VEC[v][1];
            int d = VEC[v][2];
            restart(0, p, pv, d);
            measure(0, hi, lo);
            check(hi == (p + 1) * d, "R4 high time", hi, (p + 1) * d);
            check(hi + lo == (p + 1) * (pv + 1), "R3 period length", hi + lo, (p + 1) * (pv + 1));
        end

        // R5: the force-high bit overrides a small duty count
        restart(0, 0, 9, 32'h400 | 2);
        sample_high(0, 40, highs);
        check(highs == 40, "R5 force high", highs, 40);

        // R6: duty zero is constant low; duty above the period count is constant high
        restart(0, 0, 9, 0);
        sample_high(0, 40, highs);
        check(highs == 0, "R6 duty zero low", highs, 0);
        restart(0, 0, 9, 15);
        sample_high(0, 40, highs);
        check(highs == 40, "R6 duty over period high", highs, 40);

        // R7: a duty write in mid-period waits for the boundary
        restart(0, 0, 9, 3);
        wait_rise(0);
        bus_addr  = 5'd4;
        bus_wdata = 16'd7;
        bus_we    = 1'b1;
        hi = 1;
        @(negedge clk);
        bus_we = 1'b0;
        while (pwm_out[0] === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
        check(hi == 3, "R7 current period keeps old duty", hi, 3);
        measure(0, hi, lo);
        check(hi == 7, "R7 next period new duty", hi, 7);
        check(lo == 3, "R7 next period low part", lo, 3);

        // R9: abrupt stop with the stop-mode bit set
        restart(0, 0, 9, 5);
        wait_rise(0);
        ch_en[0] = 1'b0;
        hi = 1;
        @(negedge clk);
        while (pwm_out[0] === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
        check(hi == 1, "R9 abrupt stop", hi, 1);

        // R2: writes to a disabled channel are dropped
        wr(4, 32'h155);
        rd_check(4, 5, "R2 duty locked while disabled");
        wr(8, 32'h2);
        rd_check(8, 9, "R2 period locked while disabled");

        // R8: graceful stop finishes the period, then stays low
        restart(0, 0, 9, 5);
        wr(0, 0);
        wait_rise(0);
        ch_en[0] = 1'b0;
        hi = 1;
        @(negedge clk);
        while (pwm_out[0] === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
        check(hi == 5, "R8 graceful stop completes high time", hi, 5);
        sample_high(0, 30, highs);
        check(highs == 0, "R8 parked low after period", highs, 0);

        // R11: channel 1 runs its own setting while channel 0 is off
        restart(1, 1, 4, 2);
        measure(1, hi, lo);
        check(hi == 4, "R11 channel 1 high time", hi, 4);
        check(hi + lo == 10, "R11 channel 1 period", hi + lo, 10);
        sample_high(0, 30, highs);
        check(highs == 0, "R11 channel 0 unaffected", highs, 0);
        rd_check(4, 5, "R11 channel 0 registers unaffected");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule